// File: doc/BRIEF.md
# Dual-Mode Serial Character Receiver

This block turns a single serial input line into whole characters. A mode pin picks one of two ways to find bits. In oversampled mode the block counts ticks of a sampling enable that runs at sixteen times the bit rate. It accepts a start bit only after the line has stayed low long enough, so short glitches are dropped. It then takes each bit at its centre. In clocked mode the block samples the line on every rising edge of a bit-rate clock, and the first low sample counts as the start bit. The line rests high. The line and the bit clock each pass through a two-stage synchronizer before any decision is made.

The character length runs from five to eight bits and arrives least significant bit first. Parity can be off, even or odd, and one stop bit follows. Each finished character goes to a one-entry holding register, together with its parity, framing and overrun flags. A `rx_valid`/`rx_ready` pair presents that register downstream. `rx_valid` stays high, and the data and flags stay stable, until a cycle in which `rx_ready` is high. The serial line cannot be stalled, so back-pressure does not slow reception. If a new character finishes while the previous one is still waiting, the new one replaces it and its overrun flag is raised. A one-cycle `rx_done` strobe marks every finished character, whether or not it was accepted.

Top module: `serial_char_rx`

## Requirements
- R1: `sync_mode` = 0 selects oversampled reception driven by `tick16`. `sync_mode` = 1 selects reception clocked by rising edges of `bclk`. The mode and format inputs change only while the line is idle.
- R2: In oversampled mode, a start bit is accepted only once the line has read low on 8 consecutive `tick16` ticks. A low run of 7 ticks or fewer produces no character, and the receiver goes on hunting.
- R3: In oversampled mode, the first data bit is sampled 24 ticks after the first low tick of the start bit. Each later bit is sampled 16 ticks after the one before it, which is the centre of each bit.
- R4: In clocked mode, the line is sampled on each rising edge of `bclk`. The first low sample is the start bit, and each following rising edge samples the next bit of the frame.
- R5: Data bits arrive least significant bit first. `char_len` sets the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Bits of `rx_data` above the character length read 0.
- R6: `par_mode` sets the parity: 00 = none, 01 = even, 10 = odd, 11 = none. When parity is on, one parity bit follows the data, and `rx_par_err` is set if the data bits and the parity bit together do not have the selected parity. With parity off, `rx_par_err` is 0.
- R7: A stop bit sampled low sets `rx_frm_err` for that character.
- R8: `rx_done` is high for exactly one cycle per finished character, in the same cycle that `rx_valid` rises. `rx_valid` and `rx_data` hold until a cycle with `rx_ready` high, and `rx_valid` falls after that cycle.
- R9: If a character finishes while `rx_valid` is high and `rx_ready` is low, the new byte replaces the old one and `rx_ovr` reads 1 with it. Otherwise `rx_ovr` reads 0.
- R10: After reset, `rx_valid`, `rx_done`, `rx_data` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 0 oversampled, 1 bit-clocked |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| bclk | input | 1 | Bit-rate clock for clocked mode (synchronized inside) |
| rxd | input | 1 | Serial line, idles high (synchronized inside) |
| char_len | input | 2 | Character length code, 5 to 8 bits |
| par_mode | input | 2 | Parity selection |
| rx_ready | input | 1 | Downstream accepts the held character |
| rx_valid | output | 1 | A character is held |
| rx_data | output | 8 | Held character, right aligned |
| rx_par_err | output | 1 | Parity error of the held character |
| rx_frm_err | output | 1 | Framing error of the held character |
| rx_ovr | output | 1 | Held character overwrote an unaccepted one |
| rx_done | output | 1 | One-cycle strobe per finished character |

## Verification
The assertions assume that `tick16` and `bclk` behave as periodic strobes and that mode and format stay fixed for the length of a frame. They also assume that `rx_ready` is driven synchronously. The stimulus keeps within these limits. It derives `tick16` and `bclk` from free-running counters, and it changes mode and format only during idle line time. It changes serial data in clocked mode only on falling `bclk` edges, and it holds each oversampled bit for exactly 64 clocks, which is 16 ticks. The glitch tests rely on the fact that any run of 4·n clocks holds exactly n ticks, so that a low pulse of exactly 7 or 8 ticks can be placed.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF     = 2'b00,
    PAR_EVEN    = 2'b01,
    PAR_ODD     = 2'b10,
    PAR_OFF_ALT = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= RST_VAL;
      else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler #(
  parameter int OSR  = 16,
  parameter int QUAL = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic tick16,
  input  logic rxd_s,
  input  logic bclk_s,
  input  logic frame_end,
  output logic start_stb,
  output logic sample_stb,
  output logic sample_bit
);
  localparam int CW         = $clog2(OSR + OSR/2 + 1);
  // ticks remaining from start acceptance to first data centre
  localparam int FIRST_LOAD = OSR + OSR/2 - QUAL - 1;

  logic          running;
  logic [CW-1:0] phase_cnt;
  logic [CW-1:0] low_run;
  logic          bclk_q;
  logic          bclk_rise;

  assign bclk_rise  = bclk_s & ~bclk_q;
  assign sample_bit = rxd_s;

  always_comb begin
    start_stb  = 1'b0;
    sample_stb = 1'b0;
    if (!running) begin
      if (sync_mode) start_stb = bclk_rise & ~rxd_s;
      else           start_stb = tick16 & ~rxd_s & (low_run == CW'(QUAL));
    end else begin
      if (sync_mode) sample_stb = bclk_rise;
      else           sample_stb = tick16 & (phase_cnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      running   <= 1'b0;
      phase_cnt <= '0;
      low_run   <= '0;
    end else begin
      bclk_q <= bclk_s;
      if (frame_end) begin
        running <= 1'b0;
        low_run <= '0;
      end else if (start_stb) begin
        running   <= 1'b1;
        phase_cnt <= CW'(FIRST_LOAD);
        low_run   <= '0;
      end else if (tick16 && !sync_mode) begin
        if (!running) low_run   <= rxd_s ? '0 : low_run + 1'b1;
        else          phase_cnt <= (phase_cnt == '0) ? CW'(OSR - 1) : phase_cnt - 1'b1;
      end
    end
  end

  assert_async_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !sync_mode) |-> tick16);

  assert_sync_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && sync_mode) |-> $rose(bclk_s));

  assert_no_start_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !start_stb);
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_stb,
  input  logic              sample_stb,
  input  logic              sample_bit,
  input  logic [LEN_W-1:0]  char_len,
  input  logic [1:0]        par_mode,
  output logic              frame_end,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr
);
  localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;
  localparam int IW      = $clog2(DATA_W);

  fr_state_e         state;
  par_mode_e         pm;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     last_idx;
  logic [DATA_W-1:0] shreg;
  logic              acc;
  logic              perr_q;
  logic              par_on;

  assign pm        = par_mode_e'(par_mode);
  assign par_on    = (pm == PAR_EVEN) || (pm == PAR_ODD);
  assign last_idx  = IW'(MIN_LEN - 1) + IW'(char_len);
  assign frame_end = (state == FR_STOP) && sample_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FR_IDLE;
      idx       <= '0;
      shreg     <= '0;
      acc       <= 1'b0;
      perr_q    <= 1'b0;
      char_done <= 1'b0;
      char_data <= '0;
      char_perr <= 1'b0;
      char_ferr <= 1'b0;
    end else begin
      char_done <= 1'b0;
      unique case (state)
        FR_IDLE: if (start_stb) begin
          state  <= FR_DATA;
          idx    <= '0;
          shreg  <= '0;
          acc    <= 1'b0;
          perr_q <= 1'b0;
        end
        FR_DATA: if (sample_stb) begin
          shreg[idx] <= sample_bit;
          acc        <= acc ^ sample_bit;
          if (idx == last_idx) state <= par_on ? FR_PAR : FR_STOP;
          else                 idx   <= idx + 1'b1;
        end
        FR_PAR: if (sample_stb) begin
          perr_q <= (acc ^ sample_bit) != (pm == PAR_ODD);
          state  <= FR_STOP;
        end
        FR_STOP: if (sample_stb) begin
          char_done <= 1'b1;
          char_data <= shreg;
          char_perr <= par_on & perr_q;
          char_ferr <= ~sample_bit;
          state     <= FR_IDLE;
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  assert_stop_gives_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> char_done);

  assert_no_perr_unparity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !par_on) |-> !char_perr);
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_ovr,
  output logic              rx_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      rx_ovr     <= 1'b0;
      rx_done    <= 1'b0;
    end else begin
      rx_done <= char_done;
      if (char_done) begin
        rx_valid   <= 1'b1;
        rx_data    <= char_data;
        rx_par_err <= char_perr;
        rx_frm_err <= char_ferr;
        rx_ovr     <= rx_valid & ~rx_ready;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  assert_done_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !char_done) |=> (rx_valid && $stable(rx_data)));

  assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_valid && !rx_ready) |=> rx_ovr);
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 2,
  parameter int OSR         = 16,
  parameter int QUAL        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              tick16,
  input  logic              bclk,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  char_len,
  input  logic [1:0]        par_mode,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_ovr,
  output logic              rx_done
);
  logic              rxd_s, bclk_s;
  logic              start_stb, sample_stb, sample_bit, frame_end;
  logic              char_done, char_perr, char_ferr;
  logic [DATA_W-1:0] char_data;

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rxd (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bclk (
    .clk(clk), .rst_n(rst_n), .d(bclk), .q(bclk_s));

  rx_bit_sampler #(.OSR(OSR), .QUAL(QUAL)) u_sampler (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tick16(tick16),
    .rxd_s(rxd_s), .bclk_s(bclk_s), .frame_end(frame_end),
    .start_stb(start_stb), .sample_stb(sample_stb), .sample_bit(sample_bit));

  rx_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .char_len(char_len), .par_mode(par_mode),
    .frame_end(frame_end), .char_done(char_done), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr));

  rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_ovr(rx_ovr), .rx_done(rx_done));
endmodule

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;
  localparam int CLK_P = 10;
  localparam int BITC  = 64;   // 16 ticks of 4 clocks each

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_mode = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] char_len = 2'b11;
  logic [1:0] par_mode = 2'b00;
  logic       rx_ready = 1'b0;
  logic [1:0] tcnt = '0;
  logic [2:0] bcnt = '0;
  logic       tick16, bclk;
  logic       rx_valid, rx_par_err, rx_frm_err, rx_ovr, rx_done;
  logic [7:0] rx_data;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) begin
    tcnt <= tcnt + 2'd1;
    bcnt <= bcnt + 3'd1;
  end
  assign tick16 = (tcnt == 2'd3);
  assign bclk   = bcnt[2];

  always @(negedge clk) if (rst_n && rx_done) done_cnt++;

  serial_char_rx u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tick16(tick16), .bclk(bclk),
    .rxd(rxd), .char_len(char_len), .par_mode(par_mode), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_ovr(rx_ovr), .rx_done(rx_done));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic drive(logic v, int n);
    rxd = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic par_bit(logic [7:0] d, int nb, logic [1:0] pm);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return (pm == 2'b10) ? ~p : p;
  endfunction

  // oversampled frame; corrupt = data bits valid only in their middle half
  task automatic tx_async(logic [7:0] d, int nb, logic [1:0] pm, bit bad_par,
                          logic stop_v, bit corrupt);
    @(posedge clk); #1;
    drive(1'b0, BITC);
    for (int i = 0; i < nb; i++) begin
      if (corrupt) begin
        drive(~d[i], 16); drive(d[i], 32); drive(~d[i], 16);
      end else drive(d[i], BITC);
    end
    if (pm == 2'b01 || pm == 2'b10) drive(par_bit(d, nb, pm) ^ bad_par, BITC);
    drive(stop_v, BITC);
    drive(1'b1, 2*BITC);
  endtask

  task automatic wait_bfall();
    do begin @(posedge clk); #1; end while (bcnt != 3'd0);
  endtask

  task automatic tx_sync(logic [7:0] d, int nb, logic [1:0] pm, logic stop_v);
    wait_bfall(); rxd = 1'b0;
    for (int i = 0; i < nb; i++) begin wait_bfall(); rxd = d[i]; end
    if (pm == 2'b01 || pm == 2'b10) begin wait_bfall(); rxd = par_bit(d, nb, pm); end
    wait_bfall(); rxd = stop_v;
    wait_bfall(); rxd = 1'b1;
    repeat (3) wait_bfall();
  endtask

  task automatic ack_and_check(string req);
    @(posedge clk); #1 rx_ready = 1'b1;
    @(posedge clk); #1 rx_ready = 1'b0;
    @(negedge clk);
    check({req, " valid cleared after accept"}, rx_valid, 0);
  endtask

  task automatic expect_char(string req, int prev, logic [7:0] d, logic pe, logic fe, logic ov);
    @(negedge clk);
    check({req, " one done"}, done_cnt, prev + 1);
    check({req, " valid"}, rx_valid, 1);
    check({req, " data"}, rx_data, d);
    check({req, " perr"}, rx_par_err, pe);
    check({req, " ferr"}, rx_frm_err, fe);
    check({req, " ovr"}, rx_ovr, ov);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 valid", rx_valid, 0);
    check("R10 done", rx_done, 0);
    check("R10 data", rx_data, 0);
    check("R10 flags", {rx_par_err, rx_frm_err, rx_ovr}, 0);
  endtask

  task automatic t_async_basic();   // R1 R3 R5 R8
    int prev = done_cnt;
    sync_mode = 1'b0; char_len = 2'b11; par_mode = 2'b00;
    tx_async(8'hA5, 8, 2'b00, 0, 1'b1, 0);
    expect_char("R1_R5 async 8N1", prev, 8'hA5, 0, 0, 0);
    repeat (50) @(posedge clk);
    @(negedge clk);
    check("R8 valid held without ready", rx_valid, 1);
    check("R8 data held", rx_data, 8'hA5);
    ack_and_check("R8");
  endtask

  task automatic t_async_centre();   // R3
    int prev = done_cnt;
    tx_async(8'h6C, 8, 2'b00, 0, 1'b1, 1);
    expect_char("R3 centre sampling", prev, 8'h6C, 0, 0, 0);
    ack_and_check("R3");
  endtask

  task automatic t_parity();   // R6
    int prev = done_cnt;
    par_mode = 2'b01;
    tx_async(8'h3C, 8, 2'b01, 0, 1'b1, 0);
    expect_char("R6 even ok", prev, 8'h3C, 0, 0, 0);
    ack_and_check("R6");
    prev = done_cnt; par_mode = 2'b10;
    tx_async(8'h3D, 8, 2'b10, 1, 1'b1, 0);
    expect_char("R6 odd bad", prev, 8'h3D, 1, 0, 0);
    ack_and_check("R6");
    prev = done_cnt;
    tx_async(8'h81, 8, 2'b10, 0, 1'b1, 0);
    expect_char("R6 odd ok", prev, 8'h81, 0, 0, 0);
    ack_and_check("R6");
    par_mode = 2'b00;
  endtask

  task automatic t_short_bad_stop();   // R5 R7
    int prev = done_cnt;
    char_len = 2'b00;
    tx_async(8'hFB, 5, 2'b00, 0, 1'b0, 0);
    expect_char("R5_R7 5-bit bad stop", prev, 8'h1B, 0, 1, 0);
    ack_and_check("R7");
    char_len = 2'b11;
  endtask

  task automatic t_glitch();   // R2
    int prev = done_cnt;
    @(posedge clk); #1;
    drive(1'b0, 28);
    drive(1'b1, 2000);
    @(negedge clk);
    check("R2 7-tick low ignored: no done", done_cnt, prev);
    check("R2 7-tick low ignored: no valid", rx_valid, 0);
    drive(1'b0, 32);
    drive(1'b1, 12*BITC);
    expect_char("R2 8-tick low accepted", prev, 8'hFF, 0, 0, 0);
    ack_and_check("R2");
  endtask

  task automatic t_overrun();   // R9
    int prev = done_cnt;
    tx_async(8'h11, 8, 2'b00, 0, 1'b1, 0);
    tx_async(8'h22, 8, 2'b00, 0, 1'b1, 0);
    @(negedge clk);
    check("R9 two dones", done_cnt, prev + 2);
    check("R9 newest data", rx_data, 8'h22);
    check("R9 overrun set", rx_ovr, 1);
    ack_and_check("R9");
    prev = done_cnt;
    tx_async(8'h33, 8, 2'b00, 0, 1'b1, 0);
    expect_char("R9 no overrun after accept", prev, 8'h33, 0, 0, 0);
    ack_and_check("R9");
  endtask

  task automatic t_sync();   // R1 R4
    int prev = done_cnt;
    sync_mode = 1'b1; char_len = 2'b11; par_mode = 2'b00;
    repeat (20) @(posedge clk);
    tx_sync(8'h5A, 8, 2'b00, 1'b1);
    expect_char("R4 clocked 8N1", prev, 8'h5A, 0, 0, 0);
    ack_and_check("R4");
    prev = done_cnt; char_len = 2'b10; par_mode = 2'b01;
    tx_sync(8'h35, 7, 2'b01, 1'b1);
    expect_char("R4_R6 clocked 7E1", prev, 8'h35, 0, 0, 0);
    ack_and_check("R4");
    prev = done_cnt; char_len = 2'b01; par_mode = 2'b00;
    tx_sync(8'h2A, 6, 2'b00, 1'b0);
    expect_char("R4_R7 clocked bad stop", prev, 8'h2A, 0, 1, 0);
    ack_and_check("R4");
    sync_mode = 1'b0; char_len = 2'b11;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    repeat (20) @(posedge clk);
    t_async_basic();
    t_async_centre();
    t_parity();
    t_short_bad_stop();
    t_glitch();
    t_overrun();
    t_sync();
    summary();
    $finish;
  end
endmodule